// File: doc/BRIEF.md
# Nibble-Serial Accumulator Processor Core

This block is a small processor core built around a single 4-bit accumulator. Instructions are 1, 2 or 3 nibbles long and are fetched one nibble at a time over a 4-bit read data bus. An 8-bit address bus selects nibble-wide memory locations. The first nibble of every instruction is its opcode. The opcode groups instructions by length: bits 3:2 = 00 means no operand, 01 means one immediate nibble, and bit 3 = 1 means two address nibbles, high nibble first.

Every nibble transfer spans two cycles. The core raises its read strobe with an address in the first cycle. Memory returns the nibble during the second cycle, and the core captures it at the end of that cycle. Transfers may overlap, so one transfer's strobe can share a cycle with the previous transfer's capture cycle. Because of this, each instruction class has a fixed cycle count.

The core drives a write strobe and write data for stores. It also exposes the accumulator and the program counter so the surrounding logic can observe them.

Top module: `nibcpu_core`

## Requirements
- R1: In the first cycle after synchronous active-low reset is released, the program counter and accumulator are 0, and the core drives a read strobe at address 0.
- R2: The read strobe is high only in the first cycle of each two-cycle transfer. The opcode is read at the program counter. Operand nibbles are read from the following addresses, and an address operand is stored high nibble first.
- R3: Execution times are as follows: opcodes 0000-0011 take 3 cycles; 0100-0111 take 4 cycles; 1000-1011 take 6 cycles; 1100-1111 take 7 cycles. The accumulator updates at the end of the last cycle of its instruction and at no other time.
- R4: After an instruction that does not branch, the program counter has advanced by the instruction's length in nibbles (1, 2 or 3), modulo 256.
- R5: Opcode 0000 clears the accumulator. Opcode 0010 rotates it left by one bit, with bit 3 moving into bit 0. Opcode 0011 inverts it. Opcode 0001 leaves it unchanged.
- R6: Opcodes 0100, 0101, 0110 and 0111 set the accumulator to acc AND imm, acc OR imm, acc + imm modulo 16, and imm respectively.
- R7: Opcode 1010 loads the nibble at the operand address into the accumulator. Opcode 1011 writes the accumulator to the operand address with a one-cycle write strobe in the 5th cycle of the instruction, and leaves the accumulator unchanged.
- R8: Opcodes 1100, 1101, 1110 and 1111 read the nibble M at the operand address and set the accumulator to acc AND M, acc OR M, acc + M, and acc - M respectively, with add and subtract wrapping modulo 16.
- R9: Opcode 1000 sets the program counter to the operand address when the accumulator is 0. Otherwise execution continues at the next instruction.
- R10: Opcode 1001 branches only when accumulator bit 3 is 0 and the accumulator is nonzero.
- R11: The write strobe is asserted only by opcode 1011, never in the same cycle as the read strobe, and never while any other instruction runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | output | 8 | Nibble address for the current read or write |
| bus_rdata | input | 4 | Read data, valid in the cycle after a read strobe |
| bus_wdata | output | 4 | Write data (accumulator value) |
| bus_rd | output | 1 | Read strobe, first cycle of a transfer |
| bus_wr | output | 1 | Write strobe for a store |
| acc_q | output | 4 | Current accumulator value |
| pc_q | output | 8 | Current program counter |

## Verification
A sequencer in the wrong phase shows up within one instruction. The next opcode strobe arrives at the wrong cycle, or the accumulator changes one or more cycles early or late. The bench catches this by sampling the accumulator exactly one cycle before and exactly at the expected completion edge. A wrong program counter or wrong captured operand nibbles send the next strobe to the wrong address, which shows up as a wrong accumulator or program counter at the end of that instruction or the next one. A wrong branch decision is visible at the program counter immediately after the 6-cycle branch ends.

// File: rtl/nibcpu_pkg.sv
// Package: shared opcode, phase and address-select types for the nibble core.
// Assumes a 4-bit opcode held in the low nibble of the first instruction word.
package nibcpu_pkg;

    typedef enum logic [3:0] {
        OP_ZERO = 4'h0, OP_NOP  = 4'h1, OP_ROTL = 4'h2, OP_INV  = 4'h3,
        OP_ANDI = 4'h4, OP_ORI  = 4'h5, OP_ADDI = 4'h6, OP_LDI  = 4'h7,
        OP_BEZ  = 4'h8, OP_BGZ  = 4'h9, OP_LD   = 4'hA, OP_ST   = 4'hB,
        OP_ANDM = 4'hC, OP_ORM  = 4'hD, OP_ADDM = 4'hE, OP_SUBM = 4'hF
    } opcode_t;

    // One state per cycle slot of the longest instruction.
    typedef enum logic [2:0] {
        PH_OP_RQ   = 3'd0,  // strobe opcode read
        PH_OP_CAP  = 3'd1,  // capture opcode, strobe first operand read
        PH_N1      = 3'd2,  // capture operand 1 / execute plain ops
        PH_N2      = 3'd3,  // capture operand 2 / execute immediate ops
        PH_MEM_RQ  = 3'd4,  // data read or write strobe
        PH_MEM_CAP = 3'd5,  // capture data / load / branch decision
        PH_EXEC    = 3'd6   // execute memory ALU op
    } phase_t;

    typedef enum logic [1:0] {
        ASEL_PC   = 2'd0,
        ASEL_NEXT = 2'd1,
        ASEL_OPER = 2'd2
    } asel_t;

    function automatic logic is_plain(opcode_t op);
        return op[3:2] == 2'b00;
    endfunction

    function automatic logic is_imm(opcode_t op);
        return op[3:2] == 2'b01;
    endfunction

    function automatic logic is_addr(opcode_t op);
        return op[3];
    endfunction

    function automatic logic is_memalu(opcode_t op);
        return op[3:2] == 2'b11;
    endfunction

    function automatic logic is_branch(opcode_t op);
        return op[3:1] == 3'b100;
    endfunction

endpackage

// File: rtl/nibcpu_alu.sv
// Module: combinational accumulator ALU.
// Computes the new accumulator value from the opcode, the accumulator and
// an operand nibble. Opcodes that do not compute pass the accumulator through.
module nibcpu_alu
    import nibcpu_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  opcode_t          op,
    input  logic [NIB_W-1:0] a,
    input  logic [NIB_W-1:0] b,
    output logic [NIB_W-1:0] y
);

    // Result selection by opcode.
    always_comb begin
        unique case (op)
            OP_ZERO:           y = '0;
            OP_ROTL:           y = {a[NIB_W-2:0], a[NIB_W-1]};
            OP_INV:            y = ~a;
            OP_ANDI, OP_ANDM:  y = a & b;
            OP_ORI,  OP_ORM:   y = a | b;
            OP_ADDI, OP_ADDM:  y = a + b;
            OP_LDI:            y = b;
            OP_SUBM:           y = a - b;
            default:           y = a;
        endcase
    end

    // Subtraction must wrap so that adding the operand back restores acc (R8).
    always_comb begin
        assert_sub_wraps_R8: assert (op != OP_SUBM || NIB_W'(y + b) == a);
    end

endmodule

// File: rtl/nibcpu_pc.sv
// Module: program counter register.
// Advances by one per captured instruction nibble and loads a branch target.
// Assumes inc and load are never requested in the same cycle.
module nibcpu_pc #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);

    // Counter update: reset, branch load or nibble step.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc <= '0;
        else if (load)   pc <= target;
        else if (inc)    pc <= pc + ADDR_W'(1);
    end

    // A branch load lands exactly on the requested target (R9).
    assert_load_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> pc == $past(target));

    // A step moves by exactly one nibble, modulo the address width (R4).
    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> pc == $past(pc) + ADDR_W'(1));

endmodule

// File: rtl/nibcpu_seq.sv
// Module: fetch/decode/execute sequencer.
// Walks one phase per cycle, captures the opcode and operand nibbles from the
// read bus, and produces bus strobes and datapath enables. Assumes read data
// is valid in the cycle after the strobe.
module nibcpu_seq
    import nibcpu_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] rdata,
    output phase_t           phase_o,
    output opcode_t          ir_o,
    output logic [NIB_W-1:0] n1_o,
    output logic [NIB_W-1:0] n2_o,
    output logic [NIB_W-1:0] mdat_o,
    output logic             rd_o,
    output logic             wr_o,
    output logic             pc_inc_o,
    output logic             acc_we_o,
    output logic             ld_bus_o,
    output logic             br_slot_o,
    output asel_t            asel_o
);

    phase_t phase, phase_nxt;
    opcode_t ir;

    // Next phase: each class leaves at its own final slot.
    always_comb begin
        unique case (phase)
            PH_OP_RQ:   phase_nxt = PH_OP_CAP;
            PH_OP_CAP:  phase_nxt = PH_N1;
            PH_N1:      phase_nxt = is_plain(ir) ? PH_OP_RQ : PH_N2;
            PH_N2:      phase_nxt = is_imm(ir) ? PH_OP_RQ : PH_MEM_RQ;
            PH_MEM_RQ:  phase_nxt = PH_MEM_CAP;
            PH_MEM_CAP: phase_nxt = is_memalu(ir) ? PH_EXEC : PH_OP_RQ;
            default:    phase_nxt = PH_OP_RQ;
        endcase
    end

    // Phase register and nibble capture at the end of each capture slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_OP_RQ;
            ir     <= OP_ZERO;
            n1_o   <= '0;
            n2_o   <= '0;
            mdat_o <= '0;
        end else begin
            phase <= phase_nxt;
            if (phase == PH_OP_CAP)  ir     <= opcode_t'(rdata[3:0]);
            if (phase == PH_N1)      n1_o   <= rdata;
            if (phase == PH_N2)      n2_o   <= rdata;
            if (phase == PH_MEM_CAP) mdat_o <= rdata;
        end
    end

    // Bus strobes, counter step and accumulator enables per slot.
    always_comb begin
        rd_o      = (phase == PH_OP_RQ) || (phase == PH_OP_CAP)
                 || (phase == PH_N1 && is_addr(ir))
                 || (phase == PH_MEM_RQ && (ir == OP_LD || is_memalu(ir)));
        wr_o      = (phase == PH_MEM_RQ) && (ir == OP_ST);
        pc_inc_o  = (phase == PH_OP_CAP)
                 || (phase == PH_N1 && !is_plain(ir))
                 || (phase == PH_N2 && is_addr(ir));
        ld_bus_o  = (phase == PH_MEM_CAP) && (ir == OP_LD);
        acc_we_o  = (phase == PH_N1 && is_plain(ir))
                 || (phase == PH_N2 && is_imm(ir))
                 || ld_bus_o || (phase == PH_EXEC);
        br_slot_o = (phase == PH_MEM_CAP) && is_branch(ir);
        if (phase == PH_OP_RQ)       asel_o = ASEL_PC;
        else if (phase == PH_MEM_RQ) asel_o = ASEL_OPER;
        else                         asel_o = ASEL_NEXT;
    end

    assign phase_o = phase;
    assign ir_o    = ir;

    // The extra execute slot follows a data capture of a memory ALU op (R3, R8).
    assert_exec_after_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC) |-> ($past(phase) == PH_MEM_CAP && is_memalu(ir)));

    // Plain instructions never reach the second operand slot (R3).
    assert_plain_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_N2) |-> ($past(phase) == PH_N1 && !is_plain(ir)));

    // Writes occur only in the data slot of a store (R11).
    assert_write_store_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> ($past(phase) == PH_N2 && ir == OP_ST));

endmodule

// File: rtl/nibcpu_core.sv
// Module: top of the nibble-serial accumulator core.
// Holds the accumulator, chooses the bus address and ties the sequencer,
// ALU and program counter together. Assumes ADDR_W equals two nibbles.
module nibcpu_core
    import nibcpu_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic [NIB_W-1:0]  bus_rdata,
    output logic [NIB_W-1:0]  bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [NIB_W-1:0]  acc_q,
    output logic [ADDR_W-1:0] pc_q
);

    phase_t            phase;
    opcode_t           ir;
    asel_t             asel;
    logic [NIB_W-1:0]  n1, n2, mdat, alu_b, alu_y;
    logic              pc_inc, acc_we, ld_bus, br_slot, taken;
    logic [ADDR_W-1:0] oper_addr;

    nibcpu_seq #(.NIB_W(NIB_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdata     (bus_rdata),
        .phase_o   (phase),
        .ir_o      (ir),
        .n1_o      (n1),
        .n2_o      (n2),
        .mdat_o    (mdat),
        .rd_o      (bus_rd),
        .wr_o      (bus_wr),
        .pc_inc_o  (pc_inc),
        .acc_we_o  (acc_we),
        .ld_bus_o  (ld_bus),
        .br_slot_o (br_slot),
        .asel_o    (asel)
    );

    // Operand source: data nibble in the execute slot, else first operand.
    assign alu_b = (phase == PH_EXEC) ? mdat : n1;

    nibcpu_alu #(.NIB_W(NIB_W)) u_alu (
        .op (ir),
        .a  (acc_q),
        .b  (alu_b),
        .y  (alu_y)
    );

    // Branch condition: zero test, or signed strictly-positive test.
    assign taken     = ir[0] ? (!acc_q[NIB_W-1] && acc_q != '0) : (acc_q == '0);
    assign oper_addr = {n1, n2};

    nibcpu_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (pc_inc),
        .load   (br_slot && taken),
        .target (oper_addr),
        .pc     (pc_q)
    );

    // Accumulator update at instruction completion.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (acc_we) acc_q <= ld_bus ? bus_rdata : alu_y;
    end

    // Bus address choice per slot.
    always_comb begin
        unique case (asel)
            ASEL_PC:   bus_addr = pc_q;
            ASEL_OPER: bus_addr = oper_addr;
            default:   bus_addr = pc_q + ADDR_W'(1);
        endcase
    end

    assign bus_wdata = acc_q;

    // Read and write strobes never share a cycle (R11).
    assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // The accumulator only changes as a new opcode fetch begins (R3).
    assert_acc_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q != $past(acc_q)) |-> phase == PH_OP_RQ);

    // A counter jump other than a step comes only from a branch decision (R9).
    assert_jump_from_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_q != $past(pc_q) && pc_q != $past(pc_q) + ADDR_W'(1))
            |-> ($past(phase) == PH_MEM_CAP && $past(ir[3:1]) == 3'b100));

    // A taken positive-test branch never sees a negative accumulator (R10).
    assert_bgz_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(br_slot) && $past(ir) == OP_BGZ && $past(acc_q[NIB_W-1]))
            |-> pc_q == $past(pc_q));

endmodule

// File: tb/tb_nibcpu_core.sv
`timescale 1ns/1ps
// Directed bench: each task loads a short program, resets the core and checks
// accumulator, program counter, bus and memory at exact cycle edges.
module tb_nibcpu_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr;
    logic [3:0] bus_rdata = '0;
    logic [3:0] bus_wdata;
    logic       bus_rd, bus_wr;
    logic [3:0] acc_q;
    logic [7:0] pc_q;

    logic [3:0] mem [256];
    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int wr_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nibcpu_core dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .acc_q(acc_q), .pc_q(pc_q)
    );

    // Nibble memory: one-cycle read latency, write on strobe.
    always @(posedge clk) begin
        if (bus_rd) bus_rdata <= mem[bus_addr];
        if (bus_wr) begin
            mem[bus_addr] <= bus_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wipe();
        for (int i = 0; i < 256; i++) mem[i] = 4'h0;
    endtask

    task automatic start();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        wr_cnt = 0;
    endtask

    // Advance until n edges have passed since reset release, sample at negedge.
    task automatic upto(input int n);
        repeat (n - cyc) @(posedge clk);
        @(negedge clk);
        cyc = n;
    endtask

    task automatic t_reset();
        wipe();
        mem[0] = 4'h7; mem[1] = 4'h5;
        start();
        chk("R1 pc", pc_q, 0);
        chk("R1 acc", acc_q, 0);
        chk("R1 rd", bus_rd, 1);
        chk("R1 addr", bus_addr, 0);
        upto(4);
        chk("R1 acc loaded", acc_q, 5);
        start();
        chk("R1 acc after re-reset", acc_q, 0);
        chk("R1 pc after re-reset", pc_q, 0);
    endtask

    task automatic t_immediate();
        wipe();
        mem[0] = 4'h7; mem[1] = 4'h5;   // LDI 5
        mem[2] = 4'h6; mem[3] = 4'h3;   // ADDI 3
        mem[4] = 4'h4; mem[5] = 4'h6;   // ANDI 6
        mem[6] = 4'h5; mem[7] = 4'h9;   // ORI 9
        mem[8] = 4'h7; mem[9] = 4'hF;   // LDI F
        mem[10] = 4'h6; mem[11] = 4'h3; // ADDI 3
        start();
        upto(1);
        chk("R2 operand read addr", bus_addr, 1);
        upto(2);
        chk("R2 no strobe in capture-only slot", bus_rd, 0);
        upto(3);
        chk("R3 imm not done at 3", acc_q, 0);
        upto(4);
        chk("R6 LDI", acc_q, 5);
        chk("R4 pc +2", pc_q, 2);
        upto(7);
        chk("R3 imm ADDI not done at 3", acc_q, 5);
        upto(8);
        chk("R6 ADDI", acc_q, 8);
        upto(12);
        chk("R6 ANDI", acc_q, 0);
        upto(16);
        chk("R6 ORI", acc_q, 9);
        chk("R4 pc after four imm", pc_q, 8);
        upto(24);
        chk("R6 ADDI wrap", acc_q, 2);
        chk("R11 no writes", wr_cnt, 0);
    endtask

    task automatic t_plain();
        wipe();
        mem[0] = 4'h7; mem[1] = 4'h9;   // LDI 9
        mem[2] = 4'h2;                  // rotate
        mem[3] = 4'h3;                  // invert
        mem[4] = 4'h1;                  // no-op
        mem[5] = 4'h0;                  // clear
        start();
        upto(6);
        chk("R3 plain not done at 2", acc_q, 9);
        upto(7);
        chk("R5 rotate left", acc_q, 3);
        chk("R4 pc +1", pc_q, 3);
        upto(10);
        chk("R5 invert", acc_q, 4'hC);
        upto(13);
        chk("R5 no-op keeps acc", acc_q, 4'hC);
        chk("R4 no-op pc", pc_q, 5);
        upto(16);
        chk("R5 clear", acc_q, 0);
        chk("R4 pc after clear", pc_q, 6);
    endtask

    task automatic t_load_store();
        wipe();
        mem[0] = 4'h7; mem[1] = 4'h6;                 // LDI 6
        mem[2] = 4'hB; mem[3] = 4'h4; mem[4] = 4'h0;  // ST 40
        mem[5] = 4'h7; mem[6] = 4'h1;                 // LDI 1
        mem[7] = 4'hA; mem[8] = 4'h4; mem[9] = 4'h0;  // LD 40
        start();
        upto(6);
        chk("R2 low addr nibble read", bus_addr, 4);
        chk("R2 strobe for low nibble", bus_rd, 1);
        upto(8);
        chk("R7 write strobe 5th cycle", bus_wr, 1);
        chk("R11 no read with write", bus_rd, 0);
        chk("R7 write addr", bus_addr, 8'h40);
        chk("R7 write data", bus_wdata, 6);
        upto(10);
        chk("R7 memory written", mem[8'h40], 6);
        chk("R7 store keeps acc", acc_q, 6);
        chk("R4 pc +3", pc_q, 5);
        chk("R11 single write", wr_cnt, 1);
        upto(19);
        chk("R3 load not done at 5", acc_q, 1);
        upto(20);
        chk("R7 load", acc_q, 6);
        chk("R4 pc after load", pc_q, 10);
    endtask

    task automatic t_mem_alu();
        wipe();
        mem[8'h80] = 4'hA; mem[8'h81] = 4'h7;
        mem[0] = 4'h7; mem[1] = 4'h5;                   // LDI 5
        mem[2] = 4'hC; mem[3] = 4'h8; mem[4] = 4'h0;    // AND [80]
        mem[5] = 4'h7; mem[6] = 4'h5;                   // LDI 5
        mem[7] = 4'hD; mem[8] = 4'h8; mem[9] = 4'h0;    // OR [80]
        mem[10] = 4'hE; mem[11] = 4'h8; mem[12] = 4'h1; // ADD [81]
        mem[13] = 4'hF; mem[14] = 4'h8; mem[15] = 4'h1; // SUB [81]
        start();
        upto(10);
        chk("R3 mem ALU not done at 6", acc_q, 5);
        upto(11);
        chk("R8 AND mem", acc_q, 0);
        upto(22);
        chk("R8 OR mem", acc_q, 4'hF);
        upto(29);
        chk("R8 ADD mem wrap", acc_q, 6);
        upto(36);
        chk("R8 SUB mem wrap", acc_q, 4'hF);
        chk("R4 pc after mem ops", pc_q, 16);
    endtask

    task automatic t_branch();
        // zero-test taken
        wipe();
        mem[0] = 4'h0;
        mem[1] = 4'h8; mem[2] = 4'h2; mem[3] = 4'h0;
        mem[8'h20] = 4'h7; mem[8'h21] = 4'h3;
        start();
        upto(8);
        chk("R9 pc before decision", pc_q, 4);
        upto(9);
        chk("R9 zero-test taken", pc_q, 8'h20);
        upto(13);
        chk("R9 runs target code", acc_q, 3);
        // zero-test not taken
        wipe();
        mem[0] = 4'h7; mem[1] = 4'h1;
        mem[2] = 4'h8; mem[3] = 4'h2; mem[4] = 4'h0;
        mem[5] = 4'h7; mem[6] = 4'h2;
        start();
        upto(10);
        chk("R9 zero-test not taken", pc_q, 5);
        upto(14);
        chk("R9 falls through", acc_q, 2);
        // positive-test with 7, 8, 0
        wipe();
        mem[0] = 4'h7; mem[1] = 4'h7;
        mem[2] = 4'h9; mem[3] = 4'h3; mem[4] = 4'h0;
        start();
        upto(10);
        chk("R10 positive taken", pc_q, 8'h30);
        mem[1] = 4'h8;
        start();
        upto(10);
        chk("R10 negative not taken", pc_q, 5);
        wipe();
        mem[0] = 4'h0;
        mem[1] = 4'h9; mem[2] = 4'h3; mem[3] = 4'h0;
        start();
        upto(9);
        chk("R10 zero not taken", pc_q, 4);
    endtask

    initial begin
        t_reset();
        t_immediate();
        t_plain();
        t_load_store();
        t_mem_alu();
        t_branch();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", 20000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule